// File: doc/BRIEF.md
# Two-Wire Bus Master Word Engine

This block is the bus-master half of a two-wire serial interface that moves one data word per software action. Software picks the direction, the word length and whether an acknowledge clock follows the data. It then writes the data buffer. In transmit mode the written value is shifted out onto SDA. In receive mode a dummy write, or a write of 1 to the pending flag, clocks data in from the slave.

When the last clock of the word has finished, the engine parks with SCL pulled low. It drops its active-low pending flag, pulses an interrupt request for one cycle, and records the last bit it sampled from the bus. It then waits for the next software action. The SCL high and low phases each last a programmable number of system clock cycles. SDA moves only while SCL is low.

The data buffer is a single shift register. Transmit bits leave from its top bit, and received bits enter at its bottom bit, so a received short word is right-aligned when software reads it back. Generating start and stop conditions is the job of a neighbouring block.

Top module: `i2c_word_master`

## Requirements
- R1: The 3-bit length code sets the number of data clocks per word: code 000 gives 8 data clocks, and any other code gives as many data clocks as its value (1 to 7).
- R2: When acknowledge is enabled, one extra clock follows the data clocks, so an 8-bit word uses 9 SCL clocks. When acknowledge is disabled, no extra clock is generated.
- R3: In transmit mode the data goes out MSB first from buffer bit 7 downward, so a word of n bits sends buffer bits 7 down to 8-n. The engine pulls SDA low for a 0 bit and releases it for a 1 bit, and it releases SDA during the acknowledge clock.
- R4: In receive mode the engine releases SDA during the data clocks. Each sampled bit is shifted into buffer bit 0, and `rd_data` shows the buffer. With acknowledge enabled, the engine pulls SDA low during the acknowledge clock.
- R5: A buffer write (`wr_en`) or a pending-flag write (`set_pend`) received while the engine is parked or idle starts a word. `pend_n` reads 1 (not pending) for as long as the word is running.
- R6: After the final clock of a word, `pend_n` goes to 0, `irq` pulses high for exactly one cycle, and SCL stays pulled low until the next start.
- R7: `last_rx` holds the SDA level sampled on the final clock of the word. That is the acknowledge bit when acknowledge is enabled; 0 means the receiver wants more data and 1 means it does not. Otherwise it is the last data bit.
- R8: The SCL low and high phases each last `half_div` system clock cycles. SDA changes only while SCL is low.
- R9: The length code, acknowledge enable and direction are captured when a word starts. Configuration writes made during a word do not affect that word; they apply from the next start.
- R10: Buffer writes and pending-flag writes made while a word is running are ignored. They neither change the bits sent nor start an extra word.
- R11: After reset SCL and SDA are both released, `pend_n` is 1 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Data buffer write strobe; starts a word when not busy |
| wr_data | input | 8 | Value written to the data buffer |
| set_pend | input | 1 | Write of 1 to the pending flag; starts a word with the current buffer |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_len | input | 3 | Word length code (000 = 8 bits) |
| cfg_ack | input | 1 | Acknowledge clock enable |
| cfg_tx | input | 1 | 1 = transmit, 0 = receive |
| half_div | input | 8 | SCL half period in system clocks (0 acts as 1) |
| sda_in | input | 1 | Sampled SDA line level |
| scl_out | output | 1 | 1 = SCL released high, 0 = SCL pulled low |
| sda_pull | output | 1 | 1 = pull SDA low |
| rd_data | output | 8 | Data buffer contents |
| pend_n | output | 1 | Pending flag, 0 = word complete and awaiting service |
| irq | output | 1 | One-cycle interrupt request at word completion |
| last_rx | output | 1 | Last bit sampled from SDA |

## Verification
On every cycle the assertions check the bus and completion rules. SDA must hold steady while SCL stays high. A pending engine must keep SCL low. The interrupt must be a single-cycle pulse that comes with the falling edge of the pending flag. The directed scenarios run against a slave model written in the bench, and they alone can show the end-to-end results. Those results are the bit order and the clock count for each length code, the acknowledge handshake in both directions, the received data value, and the phase lengths. They also show that configuration and buffer writes made in the middle of a word change nothing until the next start.

// File: rtl/i2cw_pkg.sv
// Package: shared widths, the engine phase type and the word-length decode.
// Assumes an 8-bit data buffer and a 3-bit length code.
package i2cw_pkg;
    localparam int BUF_W  = 8;
    localparam int LEN_W  = 3;
    localparam int SLOT_W = $clog2(BUF_W + 2);

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2,
        PH_PARK = 2'd3
    } phase_t;

    // Length code to data clock count: zero selects a full buffer.
    function automatic logic [SLOT_W-1:0] word_len(input logic [LEN_W-1:0] code);
        if (code == '0) return SLOT_W'(BUF_W);
        return SLOT_W'(code);
    endfunction
endpackage

// File: rtl/i2cw_divider.sv
// Half-period divider: while run is high, pulses tick on the last cycle of
// every half_div-cycle window. Held at zero while not running so that each
// word starts on a full phase. A divisor of 0 behaves as 1.
module i2cw_divider #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half_div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = run && ((cnt + 1'b1) >= half_div);

    // Count system clocks within the current half phase.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) cnt <= '0;
        else                        cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/i2cw_shreg.sv
// Data buffer: loads on a software write and shifts left by one bit on each
// data clock, taking the sampled SDA level into bit 0. Bit W-1 is the next
// bit to transmit. Assumes load and shift never coincide.
module i2cw_shreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    input  logic         bit_in,
    output logic [W-1:0] q
);
    // Hold, load or shift the buffer.
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= '0;
        else if (load)  q <= load_val;
        else if (shift) q <= {q[W-2:0], bit_in};
    end
endmodule

// File: rtl/i2c_word_master.sv
// Two-wire bus master word engine. Runs one word of data clocks, plus an
// optional acknowledge clock, per software start, then parks with SCL low and
// the pending flag cleared. Assumes SCL is driven only by this engine (no
// clock stretching) and that start/stop conditions come from elsewhere.
module i2c_word_master
    import i2cw_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [BUF_W-1:0] wr_data,
    input  logic             set_pend,
    input  logic             cfg_wr,
    input  logic [LEN_W-1:0] cfg_len,
    input  logic             cfg_ack,
    input  logic             cfg_tx,
    input  logic [DIV_W-1:0] half_div,
    input  logic             sda_in,
    output logic             scl_out,
    output logic             sda_pull,
    output logic [BUF_W-1:0] rd_data,
    output logic             pend_n,
    output logic             irq,
    output logic             last_rx
);
    phase_t            ph;
    logic              busy, start, tick, data_slot, last_slot, do_shift;
    logic [SLOT_W-1:0] slot, act_len;
    logic              act_ack, act_tx;
    logic [LEN_W-1:0]  cfg_len_q;
    logic              cfg_ack_q, cfg_tx_q;

    assign busy      = (ph == PH_LOW) || (ph == PH_HIGH);
    assign start     = !busy && (wr_en || set_pend);
    assign data_slot = slot < act_len;
    assign last_slot = slot == (act_len + SLOT_W'(act_ack) - 1'b1);
    assign do_shift  = (ph == PH_HIGH) && tick && data_slot;

    i2cw_divider #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .run(busy), .half_div(half_div), .tick(tick)
    );

    i2cw_shreg #(.W(BUF_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .load(wr_en && !busy), .load_val(wr_data),
        .shift(do_shift), .bit_in(sda_in), .q(rd_data)
    );

    // Configuration shadow: software writes land here at any time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_len_q <= '0;
            cfg_ack_q <= 1'b0;
            cfg_tx_q  <= 1'b1;
        end else if (cfg_wr) begin
            cfg_len_q <= cfg_len;
            cfg_ack_q <= cfg_ack;
            cfg_tx_q  <= cfg_tx;
        end
    end

    // Phase sequencer: start, low/high phase alternation, park on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph      <= PH_IDLE;
            slot    <= '0;
            act_len <= SLOT_W'(BUF_W);
            act_ack <= 1'b0;
            act_tx  <= 1'b1;
            pend_n  <= 1'b1;
            irq     <= 1'b0;
            last_rx <= 1'b1;
        end else begin
            irq <= 1'b0;
            if (start) begin
                ph      <= PH_LOW;
                slot    <= '0;
                act_len <= word_len(cfg_len_q);
                act_ack <= cfg_ack_q;
                act_tx  <= cfg_tx_q;
                pend_n  <= 1'b1;
            end else if (tick && ph == PH_LOW) begin
                ph <= PH_HIGH;
            end else if (tick && ph == PH_HIGH) begin
                last_rx <= sda_in;
                if (last_slot) begin
                    ph     <= PH_PARK;
                    pend_n <= 1'b0;
                    irq    <= 1'b1;
                end else begin
                    ph   <= PH_LOW;
                    slot <= slot + 1'b1;
                end
            end
        end
    end

    // Line drive: SCL follows the phase; SDA from buffer MSB or ack policy.
    always_comb begin
        scl_out  = (ph == PH_IDLE) || (ph == PH_HIGH);
        sda_pull = 1'b0;
        if (busy) begin
            if (data_slot) sda_pull = act_tx && !rd_data[BUF_W-1];
            else           sda_pull = !act_tx && act_ack;
        end
    end
endmodule

// Checker: cycle-level bus and completion rules of the word engine.
module i2cw_checker (
    input logic clk,
    input logic rst_n,
    input logic scl_out,
    input logic sda_pull,
    input logic pend_n,
    input logic irq
);
    AST_SDA_STILL_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_out && $past(scl_out)) |-> $stable(sda_pull)); // R8
    AST_PARK_HOLDS_SCL: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_n |-> !scl_out); // R6
    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq); // R6
    AST_IRQ_WITH_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pend_n) |-> irq); // R6
    AST_IRQ_MEANS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !pend_n); // R5
endmodule

bind i2c_word_master i2cw_checker u_i2cw_checker (
    .clk(clk), .rst_n(rst_n), .scl_out(scl_out), .sda_pull(sda_pull),
    .pend_n(pend_n), .irq(irq)
);

// File: tb/i2c_word_master_bench.sv
module i2c_word_master_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, set_pend = 1'b0, cfg_wr = 1'b0;
    logic [7:0] wr_data = '0;
    logic [2:0] cfg_len = '0;
    logic       cfg_ack = 1'b0, cfg_tx = 1'b1;
    logic [7:0] half_div = 8'd4;
    logic       sda_in, scl_out, sda_pull, pend_n, irq, last_rx;
    logic [7:0] rd_data;

    int total = 0, bad = 0;

    // Slave model and bus monitor state.
    logic        scl_d, slave_q, slave_next;
    int          rise_total, irq_total, slave_base, slave_n;
    logic [63:0] cap;
    logic        slave_tx = 1'b0, slave_ack = 1'b0;
    logic [7:0]  slave_word = '0;
    logic        sda_line;

    // Results of the last word.
    int   got_rises, got_irqs;
    logic pend_mid;

    always #5 clk = ~clk;

    i2c_word_master u_i2c_word_master (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .set_pend(set_pend), .cfg_wr(cfg_wr), .cfg_len(cfg_len),
        .cfg_ack(cfg_ack), .cfg_tx(cfg_tx), .half_div(half_div),
        .sda_in(sda_in), .scl_out(scl_out), .sda_pull(sda_pull),
        .rd_data(rd_data), .pend_n(pend_n), .irq(irq), .last_rx(last_rx)
    );

    assign sda_line = slave_q && !sda_pull;
    assign sda_in   = sda_line;

    always_comb begin
        int idx;
        idx = rise_total - slave_base;
        slave_next = 1'b1;
        if (slave_tx) begin
            if (idx >= 0 && idx < slave_n) slave_next = slave_word[slave_n-1-idx];
        end else if (idx == slave_n) begin
            slave_next = slave_ack;
        end
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            scl_d <= 1'b1; rise_total <= 0; irq_total <= 0; cap <= '0; slave_q <= 1'b1;
        end else begin
            scl_d <= scl_out;
            if (scl_out && !scl_d) begin
                rise_total <= rise_total + 1;
                cap <= {cap[62:0], sda_line};
            end
            if (irq) irq_total <= irq_total + 1;
            if (!scl_out) slave_q <= slave_next;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Run one word: optional config write, start by buffer or pending write,
    // optional meddling writes mid-word, then wait for completion.
    task automatic run_word(input bit do_cfg, input bit tx, input logic [2:0] len,
                            input bit ack, input logic [7:0] data, input bit by_pend,
                            input int n_bits, input logic [7:0] sw, input bit sack,
                            input bit meddle);
        int rb, ib, waited;
        @(negedge clk);
        if (do_cfg) begin
            cfg_wr = 1'b1; cfg_len = len; cfg_ack = ack; cfg_tx = tx;
            @(negedge clk);
            cfg_wr = 1'b0;
        end
        slave_tx = !tx; slave_word = sw; slave_ack = sack; slave_n = n_bits;
        slave_base = rise_total; rb = rise_total; ib = irq_total;
        if (by_pend) set_pend = 1'b1;
        else begin wr_en = 1'b1; wr_data = data; end
        @(negedge clk);
        set_pend = 1'b0; wr_en = 1'b0;
        pend_mid = pend_n;
        if (meddle) begin
            repeat (12) @(negedge clk);
            wr_en = 1'b1; wr_data = 8'hFF; set_pend = 1'b1;
            cfg_wr = 1'b1; cfg_len = 3'd3; cfg_ack = 1'b0; cfg_tx = tx;
            @(negedge clk);
            wr_en = 1'b0; set_pend = 1'b0; cfg_wr = 1'b0;
        end
        waited = 0;
        while (irq_total == ib && waited < 3000) begin
            @(negedge clk);
            waited++;
        end
        if (waited >= 3000) check("word completion timeout", 1, 0);
        repeat (3) @(negedge clk);
        got_rises = rise_total - rb;
        got_irqs  = irq_total - ib;
    endtask

    task automatic t_reset;
        check("R11 scl released", scl_out, 1);
        check("R11 sda released", sda_pull, 0);
        check("R11 pend_n idle", pend_n, 1);
        check("R11 irq low", irq, 0);
    endtask

    task automatic t_tx_full;
        run_word(1, 1, 3'd0, 1, 8'hA5, 0, 8, 8'h00, 1'b0, 0);
        check("R1 R2 nine clocks", got_rises, 9);
        check("R3 tx bits msb first", cap[8:1], 8'hA5);
        check("R7 ack stored", last_rx, 0);
        check("R6 pend_n cleared", pend_n, 0);
        check("R6 scl parked low", scl_out, 0);
        check("R6 one irq", got_irqs, 1);
        check("R5 pend_n set during word", pend_mid, 1);
    endtask

    task automatic t_tx_nack;
        run_word(1, 1, 3'd0, 1, 8'h3C, 0, 8, 8'h00, 1'b1, 0);
        check("R3 sda released in ack slot", cap[0], 1);
        check("R7 nack stored", last_rx, 1);
        check("R3 tx bits", cap[8:1], 8'h3C);
    endtask

    task automatic t_rx_full;
        run_word(1, 0, 3'd0, 1, 8'h00, 0, 8, 8'h96, 1'b1, 0);
        check("R4 rx data", rd_data, 8'h96);
        check("R4 master ack low", cap[0], 0);
        check("R2 rx nine clocks", got_rises, 9);
    endtask

    task automatic t_rx_pend;
        run_word(0, 0, 3'd0, 1, 8'h00, 1, 8, 8'h5A, 1'b1, 0);
        check("R5 pending write starts rx", rd_data, 8'h5A);
        check("R5 pend_n set during word", pend_mid, 1);
        check("R6 one irq after pend start", got_irqs, 1);
    endtask

    task automatic t_rx_short;
        run_word(1, 0, 3'd3, 0, 8'h00, 0, 3, 8'h05, 1'b1, 0);
        check("R1 three clocks", got_rises, 3);
        check("R2 no ack clock", got_rises, 3);
        check("R4 short rx right aligned", rd_data, 8'h05);
        check("R7 last data bit", last_rx, 1);
    endtask

    task automatic t_tx_short;
        run_word(1, 1, 3'd5, 0, 8'hB8, 0, 5, 8'h00, 1'b1, 0);
        check("R1 five clocks", got_rises, 5);
        check("R3 top five bits", cap[4:0], 5'h17);
    endtask

    task automatic t_timing;
        int hi, lo;
        @(negedge clk);
        slave_tx = 1'b0; slave_n = 8; slave_base = rise_total; slave_ack = 1'b0;
        cfg_wr = 1'b1; cfg_len = 3'd0; cfg_ack = 1'b1; cfg_tx = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0; wr_en = 1'b1; wr_data = 8'h55;
        @(negedge clk);
        wr_en = 1'b0;
        while (!scl_out) @(negedge clk);
        hi = 0; while (scl_out)  begin hi++; @(negedge clk); end
        lo = 0; while (!scl_out) begin lo++; @(negedge clk); end
        check("R8 high phase", hi, 4);
        check("R8 low phase", lo, 4);
        while (pend_n) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic t_meddle;
        run_word(1, 1, 3'd0, 1, 8'hC3, 0, 8, 8'h00, 1'b0, 1);
        check("R9 length kept mid-word", got_rises, 9);
        check("R10 buffer write ignored", cap[8:1], 8'hC3);
        check("R10 no extra word", got_irqs, 1);
        run_word(0, 1, 3'd0, 0, 8'h80, 0, 3, 8'h00, 1'b1, 0);
        check("R9 new length at next start", got_rises, 3);
        check("R9 next word bits", cap[2:0], 3'b100);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check("watchdog expired", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_tx_full;
        t_tx_nack;
        t_rx_full;
        t_rx_pend;
        t_rx_short;
        t_tx_short;
        t_timing;
        t_meddle;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule